// File: doc/BRIEF.md
# Serial One-Hot Bit Counter

This block counts how many bits of an N-bit word are set and reports that count as a one-hot vector of N+1 bits. The set bit sits at the index equal to the count. The block uses no adder. A single marker bit moves through a short register, and each input bit steers one move. A set input bit shifts the marker up one place. A clear input bit applies a right shift followed by a left shift, which leaves the marker where it was.

The marker starts one place above its logical origin, so a right shift can never push it out of the register. A final right shift removes that offset when the result is formed. The block reads one input bit per clock, least significant bit first.

A client pulses `start` with the word on `dataIn` while the block is idle. `busy` then stays high while the block works. A one-cycle `done` pulse marks the clock cycle in which `result` becomes valid, and `result` keeps that value until the next run finishes.

Top module: `onehotTally`

## Requirements
- R1: After a run, `result` (N+1 bits) has exactly one bit set, at index k, where k is the number of 1 bits in the word captured at start.
- R2: A start accepted at clock edge E raises `busy` after E. `busy` stays high for N+1 cycles. `done` is high in the cycle after edge E+N+1, which is when the new `result` appears.
- R3: An all-zero word yields a `result` with only bit 0 set.
- R4: An all-ones word yields a `result` with only bit N set.
- R5: A `start` pulse while `busy` is high is ignored. The run in progress keeps its timing, and its result counts the bits of the first word.
- R6: `done` is high for exactly one cycle per run, and `done` and `busy` are never high together. `result` changes only in a cycle where `done` is high, and otherwise holds its value.
- R7: During and after reset, with no start yet, `busy` and `done` are low and `result` is all zeros.
- R8: A `start` in the same cycle as `done` is accepted, so runs can follow one another with no idle cycle between them.
- R9: `dataIn` is sampled only at the accepting edge. Changes to it during a run do not affect that run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a count, taken only while idle |
| dataIn | input | N | Word whose set bits are counted |
| busy | output | 1 | High while a count is in progress |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | N+1 | One-hot count, bit k set for k ones |

## Verification
The hardest cases to reach are the marker edges. All ones pushes the marker into the top guard position of the register. All zeros applies repeated right-then-left steps to a marker that sits just above bit 0. The bench reaches both with dedicated words, and it also uses words with only the lowest or only the highest bit set, which checks that the bits are read in order. For the timing cases, a second start is placed in the middle of a run, and another start is placed exactly in the `done` cycle. In both runs the bench changes `dataIn` after the accepting edge.

// File: rtl/onehotTallyPkg.sv
package onehotTallyPkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_FINISH = 2'd2
  } tallyState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // capture word, seed marker
    logic step;    // consume one input bit
    logic finish;  // drop guard offset into result
  } ctrlStrobes_t;

endpackage

// File: rtl/onehotTallyCtrl.sv
module onehotTallyCtrl
  import onehotTallyPkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output ctrlStrobes_t strobes,
  output logic         busy,
  output logic         done
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LOAD_COUNT = CW'(N);
  localparam logic [CW-1:0] LAST_COUNT = CW'(1);

  tallyState_e state;
  logic [CW-1:0] remain;

  always_comb begin
    strobes.load   = (state == ST_IDLE) && start;
    strobes.step   = (state == ST_RUN);
    strobes.finish = (state == ST_FINISH);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      remain <= '0;
      done   <= 1'b0;
    end else begin
      done <= strobes.finish;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_RUN;
            remain <= LOAD_COUNT;
          end
        end
        ST_RUN: begin
          remain <= remain - 1'b1;
          if (remain == LAST_COUNT) state <= ST_FINISH;
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/onehotTallyPath.sv
module onehotTallyPath
  import onehotTallyPkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic [N-1:0] dataIn,
  output logic [N:0]   result
);
  localparam int MW = N + 2;                     // guard bit plus top count
  localparam logic [MW-1:0] SEED = MW'(2);       // marker starts at binary 10

  logic [N-1:0]  wordSh;
  logic [MW-1:0] marker;
  logic [MW-1:0] nextMarker;
  logic          curBit;

  assign curBit = wordSh[0];

  // Per-position step cell: a one moves the marker up (shl),
  // a zero does shr then shl, which keeps it in place.
  assign nextMarker[0] = 1'b0;
  for (genvar i = 1; i < MW; i++) begin : gStep
    assign nextMarker[i] = curBit ? marker[i-1] : marker[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordSh <= '0;
      marker <= '0;
      result <= '0;
    end else begin
      if (strobes.load) begin
        wordSh <= dataIn;
        marker <= SEED;
      end else if (strobes.step) begin
        wordSh <= wordSh >> 1;
        marker <= nextMarker;
      end
      if (strobes.finish) result <= marker[MW-1:1];  // final shr
    end
  end
endmodule

// File: rtl/onehotTally.sv
module onehotTally
  import onehotTallyPkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [N-1:0] dataIn,
  output logic         busy,
  output logic         done,
  output logic [N:0]   result
);
  ctrlStrobes_t strobes;

  onehotTallyCtrl #(.N(N)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobes(strobes),
    .busy   (busy),
    .done   (done)
  );

  onehotTallyPath #(.N(N)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .dataIn (dataIn),
    .result (result)
  );
endmodule

// File: rtl/onehotTallyChk.sv
module onehotTallyChk #(
  parameter int N = 8
) (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [N:0] result
);
  int runLen;

  always_ff @(posedge clk) begin
    if (!rstN)      runLen <= 0;
    else if (!busy) runLen <= 0;
    else            runLen <= runLen + 1;
  end

  a_r1_single_hot: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $countones(result) == 1);

  a_r2_run_length: assert property (@(posedge clk) disable iff (!rstN)
    done |-> runLen == N + 1);

  a_r2_start_takes: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r6_result_holds: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));

  a_r7_idle_after_reset: assert property (@(posedge clk)
    !rstN |=> (!busy && !done));
endmodule

bind onehotTally onehotTallyChk #(.N(N)) uChk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .busy  (busy),
  .done  (done),
  .result(result)
);

// File: tb/onehotTally_test.sv
`timescale 1ns/1ps
module onehotTally_test;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN;
  logic         start;
  logic [N-1:0] dataIn;
  logic         busy;
  logic         done;
  logic [N:0]   result;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  onehotTally #(.N(N)) uut (
    .clk(clk), .rstN(rstN), .start(start), .dataIn(dataIn),
    .busy(busy), .done(done), .result(result)
  );

  function automatic logic [N:0] expectHot(input logic [N-1:0] w);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(w[i]);
    return (N+1)'(1) << c;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Start at a negedge; return at the negedge after the accepting edge.
  task automatic kick(input logic [N-1:0] w);
    start = 1'b1; dataIn = w;
    @(negedge clk);
    start = 1'b0; dataIn = ~w;   // R9: later changes must not matter
  endtask

  task automatic runCase(input logic [N-1:0] w, input string req);
    @(negedge clk);
    kick(w);
    check({req, " busy after start (R2)"}, 64'(busy), 64'd1);
    repeat (N) @(negedge clk);
    check({req, " still busy (R2)"}, 64'({busy, done}), 64'b10);
    @(negedge clk);
    check({req, " done, not busy (R2)"}, 64'({busy, done}), 64'b01);
    check({req, " result (R1)"}, 64'(result), 64'(expectHot(w)));
  endtask

  task automatic testReset();
    check("R7 busy at reset", 64'(busy), 64'd0);
    check("R7 done at reset", 64'(done), 64'd0);
    check("R7 result at reset", 64'(result), 64'd0);
  endtask

  task automatic testHold();
    logic [N:0] held;
    runCase(8'hA5, "R1 mixed");
    held = result;
    repeat (3) @(negedge clk);
    check("R6 done one cycle", 64'(done), 64'd0);
    check("R6 result holds", 64'(result), 64'(held));
  endtask

  task automatic testIgnoreBusy();
    @(negedge clk);
    kick(8'h03);
    repeat (3) @(negedge clk);
    start = 1'b1; dataIn = 8'hFF;   // R5: start while busy
    @(negedge clk);
    start = 1'b0;
    repeat (N - 4) @(negedge clk);
    check("R5 busy unchanged", 64'({busy, done}), 64'b10);
    @(negedge clk);
    check("R5 done on time", 64'({busy, done}), 64'b01);
    check("R5 result of first word", 64'(result), 64'(expectHot(8'h03)));
    @(negedge clk);
    check("R5 no extra run", 64'({busy, done}), 64'b00);
  endtask

  task automatic testBackToBack();
    runCase(8'h0F, "R8 first");
    kick(8'hF7);                    // start in done cycle
    check("R8 second accepted", 64'(busy), 64'd1);
    repeat (N) @(negedge clk);
    @(negedge clk);
    check("R8 second done", 64'(done), 64'd1);
    check("R8/R9 second result", 64'(result), 64'(expectHot(8'hF7)));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; start = 1'b0; dataIn = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    runCase(8'h00, "R3 all zeros");
    runCase(8'hFF, "R4 all ones");
    runCase(8'h01, "R1 low bit");
    runCase(8'h80, "R1 high bit");
    runCase(8'h5B, "R1 pattern");
    testHold();
    testIgnoreBusy();
    testBackToBack();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule